// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds the four flags that firmware reads after start-up to learn why the processor last left reset. Two of the flags are written by software: the power-on flag and the brown-out flag. The other two are driven only by hardware: the timeout flag and the power-down flag. A small two-state machine (`ST_AWAKE`, `ST_ASLEEP`) tracks whether the core is running or sleeping, because the same watchdog or external-reset event has a different meaning in each state.

Seven event strobes feed a fixed-priority arbiter. The inputs are power-on, brown-out, external reset, watchdog timeout, software write, sleep entry and watchdog clear. Exactly one action is taken per clock. Each action changes only the flags it owns and leaves every other flag as it was.

A combinational decoder turns the flag pattern into an encoded reset cause. Software can use that code directly instead of decoding the flags itself.

The state transitions are:
- `ST_AWAKE` to `ST_ASLEEP` on sleep entry.
- `ST_ASLEEP` to `ST_AWAKE` on a watchdog wake-up, an external reset, a power-on or a brown-out.
- Every other action, in either state, keeps the current state.

Top module: `rst_cause_status`

## Requirements
- R1: After asynchronous reset the power-on flag is 0, the brown-out flag is 0 (parameter default), the timeout and power-down flags are 1, `asleep` is 0, and `cause` reads 0 (power-on).
- R2: A power-on event, in either state, clears the power-on and brown-out flags, sets the timeout and power-down flags to 1, and returns to `ST_AWAKE`.
- R3: A brown-out event clears the brown-out flag, leaves the power-on flag unchanged, sets the timeout and power-down flags to 1, and returns to `ST_AWAKE`.
- R4: A watchdog timeout in `ST_AWAKE` clears the timeout flag, leaves the power-down flag unchanged, and stays in `ST_AWAKE`.
- R5: A watchdog timeout in `ST_ASLEEP` (a wake-up) clears both the timeout and power-down flags and moves to `ST_AWAKE`.
- R6: An external reset in `ST_AWAKE` changes no flag. In `ST_ASLEEP` it leaves timeout at 1 and power-down at 0, and moves to `ST_AWAKE`.
- R7: Sleep entry in `ST_AWAKE` sets the timeout flag, clears the power-down flag and moves to `ST_ASLEEP`. In `ST_ASLEEP` it has no effect.
- R8: A watchdog clear in `ST_AWAKE` sets both the timeout and power-down flags to 1. In `ST_ASLEEP` it has no effect.
- R9: A register write in `ST_AWAKE` loads `wr_data[0]` into the brown-out flag and `wr_data[1]` into the power-on flag. `pctl_q` shows the brown-out flag at bit 0 and the power-on flag at bit 1. A write in `ST_ASLEEP` is ignored.
- R10: When several strobes are high in one cycle, only the highest takes effect. The order, highest first, is power-on, brown-out, external reset, watchdog timeout, write, sleep, watchdog clear.
- R11: With the power-on flag at 1, `cause` is decoded from the other flags in this order:
  - 1 (brown-out) when the brown-out flag is 0 and `bor_en` is 1.
  - Otherwise, from timeout and power-down: 2 when they are 0 and 1 (watchdog reset), 3 when both are 0 (watchdog wake-up), 4 when both are 1 (external reset while running), 5 when they are 1 and 0 (external reset during sleep).
- R12: With the power-on flag at 0, `cause` is 0 when timeout and power-down are both 1, and 7 (illegal) otherwise.
- R13: With `bor_en` at 0, the brown-out flag has no effect on `cause`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bor_en | input | 1 | Brown-out detection enabled (configuration) |
| evt_por | input | 1 | Power-on event strobe |
| evt_bor | input | 1 | Brown-out event strobe |
| evt_ext | input | 1 | External reset strobe |
| evt_wdt | input | 1 | Watchdog timeout strobe |
| evt_sleep | input | 1 | Sleep-entry strobe |
| evt_wdclr | input | 1 | Watchdog-clear instruction strobe |
| wr_stb | input | 1 | Power-control register write strobe |
| wr_data | input | 2 | Write data: bit 0 brown-out, bit 1 power-on |
| pctl_q | output | 2 | Power-control register: bit 0 brown-out, bit 1 power-on |
| to_flag | output | 1 | Timeout flag |
| pd_flag | output | 1 | Power-down flag |
| asleep | output | 1 | High in `ST_ASLEEP` |
| cause | output | 3 | Encoded reset cause |

## Verification
All flags and the state bit are visible at the ports one clock after the strobe that changes them. A wrong update therefore shows up at the very next sampling point, either on a flag pin or as a changed `cause` code. A bad state transition is harder to see directly. It shows up at the first later event whose meaning depends on the state: a second sleep entry, a watchdog timeout or a write. The bench therefore follows every state change with one of those events.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    localparam int PCTL_W  = 2;
    localparam int POS_BOR = 0;
    localparam int POS_POR = 1;
    localparam int CAUSE_W = 3;

    typedef enum logic [0:0] {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } pwr_state_e;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_POWERON  = 3'd1,
        ACT_BROWNOUT = 3'd2,
        ACT_EXTRST   = 3'd3,
        ACT_WDT      = 3'd4,
        ACT_WRITE    = 3'd5,
        ACT_SLEEP    = 3'd6,
        ACT_WDCLR    = 3'd7
    } action_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_POWER_ON  = 3'd0,
        CAUSE_BROWN_OUT = 3'd1,
        CAUSE_WDT_RESET = 3'd2,
        CAUSE_WDT_WAKE  = 3'd3,
        CAUSE_EXT_RUN   = 3'd4,
        CAUSE_EXT_SLEEP = 3'd5,
        CAUSE_RSVD      = 3'd6,
        CAUSE_ILLEGAL   = 3'd7
    } cause_e;

endpackage

// File: rtl/rst_cause_arb.sv
module rst_cause_arb
    import rst_cause_pkg::*;
(
    input  logic    asleep,
    input  logic    evt_por,
    input  logic    evt_bor,
    input  logic    evt_ext,
    input  logic    evt_wdt,
    input  logic    wr_stb,
    input  logic    evt_sleep,
    input  logic    evt_wdclr,
    output action_e act
);

    // Fixed priority. Software-side actions are masked while asleep.
    always_comb begin
        if (evt_por)                    act = ACT_POWERON;
        else if (evt_bor)               act = ACT_BROWNOUT;
        else if (evt_ext)               act = ACT_EXTRST;
        else if (evt_wdt)               act = ACT_WDT;
        else if (wr_stb && !asleep)     act = ACT_WRITE;
        else if (evt_sleep && !asleep)  act = ACT_SLEEP;
        else if (evt_wdclr && !asleep)  act = ACT_WDCLR;
        else                            act = ACT_NONE;
    end

endmodule

// File: rtl/rst_cause_fsm.sv
module rst_cause_fsm
    import rst_cause_pkg::*;
#(
    parameter logic BOR_RST_VAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  action_e           act,
    input  logic [PCTL_W-1:0] wr_data,
    output logic              por_flag,
    output logic              bor_flag,
    output logic              to_flag,
    output logic              pd_flag,
    output logic              asleep
);

    pwr_state_e cur_q, cur_d;
    logic por_q, por_d, bor_q, bor_d, to_q, to_d, pd_q, pd_d;

    // State and flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= ST_AWAKE;
            por_q <= 1'b0;
            bor_q <= BOR_RST_VAL;
            to_q  <= 1'b1;
            pd_q  <= 1'b1;
        end else begin
            cur_q <= cur_d;
            por_q <= por_d;
            bor_q <= bor_d;
            to_q  <= to_d;
            pd_q  <= pd_d;
        end
    end

    // Next state and flag updates
    always_comb begin
        cur_d = cur_q;
        por_d = por_q;
        bor_d = bor_q;
        to_d  = to_q;
        pd_d  = pd_q;
        unique case (cur_q)
            ST_AWAKE: begin
                unique case (act)
                    ACT_POWERON: begin
                        por_d = 1'b0;
                        bor_d = 1'b0;
                        to_d  = 1'b1;
                        pd_d  = 1'b1;
                    end
                    ACT_BROWNOUT: begin
                        bor_d = 1'b0;
                        to_d  = 1'b1;
                        pd_d  = 1'b1;
                    end
                    ACT_EXTRST: ;
                    ACT_WDT:    to_d = 1'b0;
                    ACT_WRITE: begin
                        bor_d = wr_data[POS_BOR];
                        por_d = wr_data[POS_POR];
                    end
                    ACT_SLEEP: begin
                        to_d  = 1'b1;
                        pd_d  = 1'b0;
                        cur_d = ST_ASLEEP;
                    end
                    ACT_WDCLR: begin
                        to_d = 1'b1;
                        pd_d = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_ASLEEP: begin
                unique case (act)
                    ACT_POWERON: begin
                        por_d = 1'b0;
                        bor_d = 1'b0;
                        to_d  = 1'b1;
                        pd_d  = 1'b1;
                        cur_d = ST_AWAKE;
                    end
                    ACT_BROWNOUT: begin
                        bor_d = 1'b0;
                        to_d  = 1'b1;
                        pd_d  = 1'b1;
                        cur_d = ST_AWAKE;
                    end
                    ACT_EXTRST: begin
                        to_d  = 1'b1;
                        pd_d  = 1'b0;
                        cur_d = ST_AWAKE;
                    end
                    ACT_WDT: begin
                        to_d  = 1'b0;
                        pd_d  = 1'b0;
                        cur_d = ST_AWAKE;
                    end
                    default: ;
                endcase
            end
            default: cur_d = ST_AWAKE;
        endcase
    end

    // Outputs
    always_comb begin
        por_flag = por_q;
        bor_flag = bor_q;
        to_flag  = to_q;
        pd_flag  = pd_q;
        asleep   = (cur_q == ST_ASLEEP);
    end

endmodule

// File: rtl/rst_cause_dec.sv
module rst_cause_dec
    import rst_cause_pkg::*;
(
    input  logic   por_flag,
    input  logic   bor_flag,
    input  logic   to_flag,
    input  logic   pd_flag,
    input  logic   bor_en,
    output cause_e cause
);

    always_comb begin
        if (!por_flag) begin
            cause = (to_flag && pd_flag) ? CAUSE_POWER_ON : CAUSE_ILLEGAL;
        end else if (bor_en && !bor_flag) begin
            cause = CAUSE_BROWN_OUT;
        end else begin
            unique case ({to_flag, pd_flag})
                2'b01:   cause = CAUSE_WDT_RESET;
                2'b00:   cause = CAUSE_WDT_WAKE;
                2'b11:   cause = CAUSE_EXT_RUN;
                default: cause = CAUSE_EXT_SLEEP;
            endcase
        end
    end

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
    import rst_cause_pkg::*;
#(
    parameter logic BOR_RST_VAL = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bor_en,
    input  logic               evt_por,
    input  logic               evt_bor,
    input  logic               evt_ext,
    input  logic               evt_wdt,
    input  logic               evt_sleep,
    input  logic               evt_wdclr,
    input  logic               wr_stb,
    input  logic [PCTL_W-1:0]  wr_data,
    output logic [PCTL_W-1:0]  pctl_q,
    output logic               to_flag,
    output logic               pd_flag,
    output logic               asleep,
    output logic [CAUSE_W-1:0] cause
);

    action_e act;
    cause_e  cause_enc;
    logic    por_flag, bor_flag;

    rst_cause_arb u_arb (
        .asleep    (asleep),
        .evt_por   (evt_por),
        .evt_bor   (evt_bor),
        .evt_ext   (evt_ext),
        .evt_wdt   (evt_wdt),
        .wr_stb    (wr_stb),
        .evt_sleep (evt_sleep),
        .evt_wdclr (evt_wdclr),
        .act       (act)
    );

    rst_cause_fsm #(
        .BOR_RST_VAL (BOR_RST_VAL)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .wr_data  (wr_data),
        .por_flag (por_flag),
        .bor_flag (bor_flag),
        .to_flag  (to_flag),
        .pd_flag  (pd_flag),
        .asleep   (asleep)
    );

    rst_cause_dec u_dec (
        .por_flag (por_flag),
        .bor_flag (bor_flag),
        .to_flag  (to_flag),
        .pd_flag  (pd_flag),
        .bor_en   (bor_en),
        .cause    (cause_enc)
    );

    always_comb begin
        pctl_q          = '0;
        pctl_q[POS_BOR] = bor_flag;
        pctl_q[POS_POR] = por_flag;
        cause           = cause_enc;
    end

endmodule

// File: rtl/rst_cause_status_chk.sv
module rst_cause_status_chk
    import rst_cause_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_por,
    input logic              evt_bor,
    input logic              evt_ext,
    input logic              evt_wdt,
    input logic              evt_sleep,
    input logic              evt_wdclr,
    input logic              wr_stb,
    input logic [PCTL_W-1:0] pctl_q,
    input logic              to_flag,
    input logic              pd_flag,
    input logic              asleep
);

    logic hi_rst;
    assign hi_rst = evt_por || evt_bor || evt_ext;

    // R2
    por_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_por |=> (pctl_q == '0) && to_flag && pd_flag && !asleep);

    // R3
    bor_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_bor && !evt_por) |=> !pctl_q[POS_BOR] && to_flag && pd_flag && !asleep
                                 && (pctl_q[POS_POR] == $past(pctl_q[POS_POR])));

    // R4
    wdt_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt && !asleep && !hi_rst) |=> !to_flag && $stable(pd_flag) && !asleep);

    // R5
    wdt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt && asleep && !hi_rst) |=> !to_flag && !pd_flag && !asleep);

    // R6
    ext_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ext && !asleep && !evt_por && !evt_bor) |=>
            $stable(to_flag) && $stable(pd_flag) && $stable(pctl_q) && !asleep);

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sleep && !asleep && !hi_rst && !evt_wdt && !wr_stb) |=>
            asleep && to_flag && !pd_flag);

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_rst || evt_wdt || evt_sleep || evt_wdclr || wr_stb) |=>
            $stable(pctl_q) && $stable(to_flag) && $stable(pd_flag) && $stable(asleep));

endmodule

bind rst_cause_status rst_cause_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_por   (evt_por),
    .evt_bor   (evt_bor),
    .evt_ext   (evt_ext),
    .evt_wdt   (evt_wdt),
    .evt_sleep (evt_sleep),
    .evt_wdclr (evt_wdclr),
    .wr_stb    (wr_stb),
    .pctl_q    (pctl_q),
    .to_flag   (to_flag),
    .pd_flag   (pd_flag),
    .asleep    (asleep)
);

// File: tb/test_rst_cause_status.sv
module test_rst_cause_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bor_en = 1'b1;
    logic       evt_por = 1'b0, evt_bor = 1'b0, evt_ext = 1'b0, evt_wdt = 1'b0;
    logic       evt_sleep = 1'b0, evt_wdclr = 1'b0, wr_stb = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] pctl_q;
    logic       to_flag, pd_flag, asleep;
    logic [2:0] cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rst_cause_status i_rst_cause_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .bor_en    (bor_en),
        .evt_por   (evt_por),
        .evt_bor   (evt_bor),
        .evt_ext   (evt_ext),
        .evt_wdt   (evt_wdt),
        .evt_sleep (evt_sleep),
        .evt_wdclr (evt_wdclr),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .pctl_q    (pctl_q),
        .to_flag   (to_flag),
        .pd_flag   (pd_flag),
        .asleep    (asleep),
        .cause     (cause)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare the whole visible state: pctl, to, pd, asleep, cause
    task automatic chk_all(input string req, input int e_pctl, input int e_to,
                           input int e_pd, input int e_sl, input int e_cause);
        chk(req, "pctl_q", int'(pctl_q), e_pctl);
        chk(req, "to_flag", int'(to_flag), e_to);
        chk(req, "pd_flag", int'(pd_flag), e_pd);
        chk(req, "asleep", int'(asleep), e_sl);
        chk(req, "cause", int'(cause), e_cause);
    endtask

    // Strobes bit order: {por,bor,ext,wdt,wr,sleep,wdclr}
    task automatic pulse(input logic [6:0] s, input logic [1:0] d);
        {evt_por, evt_bor, evt_ext, evt_wdt, wr_stb, evt_sleep, evt_wdclr} = s;
        wr_data = d;
        @(negedge clk);
        {evt_por, evt_bor, evt_ext, evt_wdt, wr_stb, evt_sleep, evt_wdclr} = '0;
        wr_data = 2'b00;
    endtask

    localparam logic [6:0] S_POR = 7'b1000000, S_BOR = 7'b0100000, S_EXT = 7'b0010000,
                           S_WDT = 7'b0001000, S_WR  = 7'b0000100, S_SLP = 7'b0000010,
                           S_CLR = 7'b0000001;

    task automatic t_reset;
        chk_all("R1", 0, 1, 1, 0, 0);
    endtask

    task automatic t_write_and_decode;
        pulse(S_WR, 2'b11);
        chk_all("R9", 3, 1, 1, 0, 4);
        pulse(S_WR, 2'b01);
        chk("R9", "pctl_q after 01", int'(pctl_q), 1);
        pulse(S_WR, 2'b11);
    endtask

    task automatic t_wdt_awake;
        pulse(S_WDT, 2'b00);
        chk_all("R4", 3, 0, 1, 0, 2);
        pulse(S_CLR, 2'b00);
        chk_all("R8", 3, 1, 1, 0, 4);
    endtask

    task automatic t_sleep;
        pulse(S_SLP, 2'b00);
        chk_all("R7", 3, 1, 0, 1, 5);
        pulse(S_SLP, 2'b00);
        chk_all("R7", 3, 1, 0, 1, 5);
        pulse(S_CLR, 2'b00);
        chk("R8", "pd_flag clear ignored asleep", int'(pd_flag), 0);
        pulse(S_WR, 2'b00);
        chk("R9", "write ignored asleep", int'(pctl_q), 3);
        chk("R9", "still asleep", int'(asleep), 1);
    endtask

    task automatic t_ext;
        pulse(S_EXT, 2'b00);
        chk_all("R6", 3, 1, 0, 0, 5);
        pulse(S_EXT, 2'b00);
        chk_all("R6", 3, 1, 0, 0, 5);
        pulse(S_SLP, 2'b00);
        chk("R6", "sleep accepted after ext wake", int'(asleep), 1);
    endtask

    task automatic t_wdt_wake;
        pulse(S_WDT, 2'b00);
        chk_all("R5", 3, 0, 0, 0, 3);
        pulse(S_CLR, 2'b00);
        chk("R5", "awake after wake-up", int'(pd_flag), 1);
    endtask

    task automatic t_brownout;
        pulse(S_WDT, 2'b00);
        pulse(S_BOR, 2'b00);
        chk_all("R3", 2, 1, 1, 0, 1);
        bor_en = 1'b0;
        #1;
        chk("R13", "cause with detection off", int'(cause), 4);
        @(negedge clk);
        bor_en = 1'b1;
        #1;
        chk("R11", "cause brown-out", int'(cause), 1);
        @(negedge clk);
    endtask

    task automatic t_priority;
        pulse(S_WDT | S_WR, 2'b11);
        chk_all("R10", 2, 0, 1, 0, 1);
        pulse(S_POR | S_BOR | S_EXT, 2'b00);
        chk_all("R2", 0, 1, 1, 0, 0);
        pulse(S_EXT | S_WDT, 2'b00);
        chk("R10", "ext over wdt", int'(to_flag), 1);
        pulse(S_SLP | S_CLR, 2'b00);
        chk("R10", "sleep over clear", int'(pd_flag), 0);
        pulse(S_EXT, 2'b00);
    endtask

    task automatic t_illegal;
        chk("R12", "cause with pd cleared", int'(cause), 7);
        pulse(S_CLR, 2'b00);
        chk("R12", "power-on cause", int'(cause), 0);
        pulse(S_WDT, 2'b00);
        chk("R12", "cause with to cleared", int'(cause), 7);
    endtask

    task automatic t_por_asleep;
        pulse(S_WR, 2'b11);
        pulse(S_SLP, 2'b00);
        pulse(S_POR, 2'b00);
        chk_all("R2", 0, 1, 1, 0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_and_decode();
        t_wdt_awake();
        t_sleep();
        t_ext();
        t_wdt_wake();
        t_brownout();
        t_priority();
        t_illegal();
        t_por_asleep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule